// File: doc/BRIEF.md
# Clock Configuration and Relock Controller

This block holds one configuration word that decides where the system clock comes from and how far it is divided. The word has fields for PLL run or power-down, PLL path select, divisor enable, divisor code, reference oscillator select and crystal choice. The controller turns this word into a system clock-enable strobe, `sysclk_en`, which is high on every cycle in which the divided system clock would tick. Everything runs on the reference clock `clk`. PLL output edges arrive as single-cycle pulses on `pll_tick`.

Any write that changes the PLL run bit, the oscillator select or the crystal choice starts a relock interval of `RELOCK_CYC` reference cycles. While the interval runs, `pll_ready` is low and a request for the PLL path falls back to the bypass path. A change of crystal choice also raises a one-cycle `xlat_update` pulse, which stands in for re-deriving the PLL settings. A divisor change is taken only at a strobe boundary, so the strobe never shows a shortened period.

Top module: `clkcfg_relock`

## Requirements

The configuration word `cfg_wdata` has these fields:

| Bits | Field | Meaning |
|---|---|---|
| [0] | run | 1 = PLL normal mode, 0 = PLL power-down |
| [1] | path | 1 = request the PLL path |
| [2] | divisor enable | 1 = apply the divisor |
| [8:3] | divisor code | divisor field |
| [11:9] | oscillator select | reference oscillator |
| [15:12] | crystal choice | crystal selection |

- R1: After reset all fields are zero. The PLL is powered down, not ready and not driving, and `sysclk_en` is high on every cycle.
- R2: `pll_pwrdn` is the inverse of the run field. `pll_ready` can be high only while the run field is 1.
- R3: On the PLL path, source ticks are every second `pll_tick` pulse (a divide-by-two) before the divisor is applied. With `pll_tick` held high, the strobe period is 2·(N+1) cycles.
- R4: With the divisor enable field set, divisor code N gives a strobe every N+1 source ticks. Code 63 gives divide-by-64.
- R5: With the divisor enable field clear, no division is applied. On the bypass path `sysclk_en` is then high every cycle, whatever the divisor code.
- R6: A write that changes the crystal choice field gives `xlat_update` high for exactly the one cycle after the write. A write that leaves that field unchanged gives no pulse.
- R7: A write that changes the run, oscillator select or crystal choice fields holds `pll_ready` low for exactly `RELOCK_CYC` cycles after the write. After that, `pll_ready` is high if run is 1.
- R8: A further change of those fields during the interval restarts the full `RELOCK_CYC` count from that write.
- R9: While the path field is 1 and `pll_ready` is low, the strobe follows bypass timing and `sys_on_pll` is low. `sys_on_pll` is high only when the path field is 1 and `pll_ready` is high.
- R10: `ref_is_rtc` is high exactly when the oscillator select field holds 7, the low-frequency real-time oscillator code.
- R11: A new divisor is loaded only at a strobe. A write that lands in a cycle where `sysclk_en` is high lets the old divisor run one more full period.
- R12: Writes that change only the path, divisor enable or divisor code fields do not restart the relock interval.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 16 (CFG_W) | Configuration word, fields as in Requirements |
| pll_tick | input | 1 | One-cycle pulse for each PLL output edge |
| sysclk_en | output | 1 | System clock-enable strobe |
| pll_ready | output | 1 | PLL locked and usable |
| pll_pwrdn | output | 1 | PLL in power-down |
| sys_on_pll | output | 1 | System clock currently taken from the PLL path |
| ref_is_rtc | output | 1 | PLL reference is the real-time oscillator |
| xlat_update | output | 1 | Pulse: PLL settings re-derived after a crystal change |

## Verification

Two events can fall in the same cycle: a configuration write and the strobe boundary at which the divisor counter reloads. The bench provokes this by waiting for `sysclk_en` to be high and issuing a divisor-changing write in that same cycle. It judges the result from the next two strobe intervals: the old period must appear once more, and then the new one. A second overlap, a crystal write arriving during a running relock, is judged by counting the cycles until `pll_ready` rises from the second write.

// File: rtl/clkcfg_relock.sv
module clkcfg_relock #(
  parameter int DIV_W      = 6,
  parameter int SRC_W      = 3,
  parameter int XTAL_W     = 4,
  parameter int RELOCK_CYC = 4096,
  parameter int RTC_CODE   = 7,
  localparam int CFG_W     = 3 + DIV_W + SRC_W + XTAL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             pll_tick,
  output logic             sysclk_en,
  output logic             pll_ready,
  output logic             pll_pwrdn,
  output logic             sys_on_pll,
  output logic             ref_is_rtc,
  output logic             xlat_update
);
  localparam int DIV_LO  = 3;
  localparam int SRC_LO  = DIV_LO + DIV_W;
  localparam int XTAL_LO = SRC_LO + SRC_W;
  localparam int RLK_W   = $clog2(RELOCK_CYC + 1);
  localparam logic [RLK_W-1:0] RLK_LOAD = RLK_W'(RELOCK_CYC);

  logic [CFG_W-1:0] cfg_q;
  logic [RLK_W-1:0] rlk_cnt;
  logic [DIV_W-1:0] dcnt;
  logic             half;

  wire              run      = cfg_q[0];
  wire              path     = cfg_q[1];
  wire              div_en   = cfg_q[2];
  wire [DIV_W-1:0]  div_code = cfg_q[DIV_LO +: DIV_W];
  wire [SRC_W-1:0]  osc      = cfg_q[SRC_LO +: SRC_W];
  wire [XTAL_W-1:0] xtal     = cfg_q[XTAL_LO +: XTAL_W];

  wire xtal_chg = cfg_we && (cfg_wdata[XTAL_LO +: XTAL_W] != xtal);
  wire pll_chg  = cfg_we && ((cfg_wdata[0] != run) ||
                             (cfg_wdata[SRC_LO +: SRC_W] != osc) || xtal_chg);

  wire [DIV_W-1:0] div_req  = div_en ? div_code : '0;
  wire             src_tick = sys_on_pll ? (pll_tick & half) : 1'b1;

  assign pll_pwrdn  = ~run;
  assign pll_ready  = run && (rlk_cnt == '0);
  assign sys_on_pll = path && pll_ready;
  assign ref_is_rtc = (osc == SRC_W'(RTC_CODE));
  assign sysclk_en  = src_tick && (dcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      xlat_update <= 1'b0;
      rlk_cnt     <= '0;
    end else begin
      xlat_update <= xtal_chg;
      if (cfg_we) cfg_q <= cfg_wdata;
      if (pll_chg)              rlk_cnt <= RLK_LOAD;
      else if (rlk_cnt != '0)   rlk_cnt <= rlk_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half <= 1'b0;
      dcnt <= '0;
    end else begin
      half <= half ^ pll_tick;
      if (src_tick) dcnt <= (dcnt == '0) ? div_req : dcnt - 1'b1;
    end
  end
endmodule

// File: rtl/clkcfg_relock_chk.sv
module clkcfg_relock_chk #(
  parameter int CFG_W      = 16,
  parameter int DIV_W      = 6,
  parameter int SRC_W      = 3,
  parameter int XTAL_W     = 4,
  parameter int RELOCK_CYC = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [CFG_W-1:0] cfg_q,
  input logic             pll_ready,
  input logic             pll_pwrdn,
  input logic             sys_on_pll,
  input logic             xlat_update
);
  localparam int SRC_LO  = 3 + DIV_W;
  localparam int XTAL_LO = SRC_LO + SRC_W;
  localparam int SW      = $clog2(RELOCK_CYC + 2);

  wire x_chg = cfg_we && (cfg_wdata[XTAL_LO +: XTAL_W] != cfg_q[XTAL_LO +: XTAL_W]);
  wire p_chg = cfg_we && ((cfg_wdata[0] != cfg_q[0]) ||
               (cfg_wdata[SRC_LO +: SRC_W] != cfg_q[SRC_LO +: SRC_W]) || x_chg);

  logic [SW-1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since <= '0;
    else if (p_chg)                   since <= '0;
    else if (since != SW'(RELOCK_CYC)) since <= since + 1'b1;
  end

  assert_pwrdn_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pll_pwrdn |-> !pll_ready);
  assert_path_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_on_pll |-> pll_ready);
  assert_change_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    p_chg |=> !pll_ready);
  assert_full_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pll_ready |-> (since == SW'(RELOCK_CYC)));
  assert_xlat_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    x_chg |=> xlat_update);
  assert_xlat_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !x_chg |=> !xlat_update);
endmodule

bind clkcfg_relock clkcfg_relock_chk #(
  .CFG_W(CFG_W), .DIV_W(DIV_W), .SRC_W(SRC_W), .XTAL_W(XTAL_W), .RELOCK_CYC(RELOCK_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
  .pll_ready(pll_ready), .pll_pwrdn(pll_pwrdn), .sys_on_pll(sys_on_pll),
  .xlat_update(xlat_update)
);

// File: tb/clkcfg_relock_bench.sv
module clkcfg_relock_bench;
  localparam int RLK = 20;
  logic clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, pll_tick = 1'b1;
  logic [15:0] cfg_wdata = '0;
  logic sysclk_en, pll_ready, pll_pwrdn, sys_on_pll, ref_is_rtc, xlat_update;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  clkcfg_relock #(.RELOCK_CYC(RLK)) u_clkcfg_relock (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .pll_tick(pll_tick),
    .sysclk_en(sysclk_en), .pll_ready(pll_ready), .pll_pwrdn(pll_pwrdn),
    .sys_on_pll(sys_on_pll), .ref_is_rtc(ref_is_rtc), .xlat_update(xlat_update));

  // {config word, expected strobe period}
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'd1},   {16'h001C, 16'd4},  {16'h0018, 16'd1},  {16'h01FC, 16'd64},
    {16'h0003, 16'd2},   {16'h0027, 16'd10}, {16'h01FF, 16'd128}, {16'h000E, 16'd2}};
  localparam string VREQ [8] = '{"R5", "R4", "R5", "R4", "R3", "R3", "R3", "R9"};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic to_strobe();
    for (int i = 0; i < 1000 && !sysclk_en; i++) @(negedge clk);
  endtask

  task automatic interval(output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!sysclk_en && p < 1000);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    check("R1 ready", pll_ready, 0);
    check("R1 pwrdn", pll_pwrdn, 1);
    check("R1 on_pll", sys_on_pll, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobe", sysclk_en, 1);
    check("R1 rtc", ref_is_rtc, 0);

    for (int k = 0; k < 8; k++) begin
      wr(VEC[k][31:16]);
      repeat (RLK + 5) @(negedge clk);
      to_strobe(); interval(p); interval(p); interval(p);
      check(VREQ[k], p, int'(VEC[k][15:0]));
    end

    // R7 relock window, R2 run bit
    wr(16'h0000);
    repeat (RLK + 2) @(negedge clk);
    wr(16'h0003);
    check("R2 pwrdn", pll_pwrdn, 0);
    check("R9 fallback strobe", sysclk_en, 1);
    check("R9 on_pll", sys_on_pll, 0);
    for (int i = 0; i < RLK - 1; i++) @(negedge clk);
    check("R7 still low", pll_ready, 0);
    @(negedge clk);
    check("R7 ready", pll_ready, 1);
    check("R9 on_pll after lock", sys_on_pll, 1);

    // R12 divisor-only write keeps lock
    wr(16'h000F);
    check("R12 ready kept", pll_ready, 1);

    // R8 restart, R6 pulse
    wr(16'h0000);
    check("R2 off not ready", pll_ready, 0);
    wr(16'h0001);
    repeat (10) @(negedge clk);
    wr(16'h5001);
    check("R6 pulse", xlat_update, 1);
    @(negedge clk);
    check("R6 one cycle", xlat_update, 0);
    for (int i = 1; i < RLK - 1; i++) @(negedge clk);
    check("R8 restarted", pll_ready, 0);
    @(negedge clk);
    check("R8 ready", pll_ready, 1);
    wr(16'h5001);
    check("R6 no pulse", xlat_update, 0);
    check("R7 same write keeps lock", pll_ready, 1);

    // R10 oscillator code 7
    wr(16'h5E01);
    check("R10 rtc", ref_is_rtc, 1);
    wr(16'h5C01);
    check("R10 not rtc", ref_is_rtc, 0);

    // R11 write on the strobe cycle
    wr(16'h001C);
    repeat (RLK + 5) @(negedge clk);
    to_strobe(); interval(p);
    cfg_we = 1'b1; cfg_wdata = 16'h000C;
    p = 0;
    @(negedge clk); p++; cfg_we = 1'b0;
    while (!sysclk_en && p < 1000) begin @(negedge clk); p++; end
    check("R11 old period", p, 4);
    interval(p);
    check("R11 new period", p, 2);

    done = 1'b1;
    summary();
  end
endmodule